// File: doc/BRIEF.md
# Stuck Two-Wire Bus Recovery Controller

This controller sits beside a two-wire bus switch that joins one upstream bus to a set of downstream channels. It samples the clock and data levels of every downstream channel and combines the enabled ones into a single wired-AND view of the bus. If that view never shows clock and data high together for a full timeout window, the controller drives an active-low fault flag.

Recovery may be disabled. In that case the flag is the only thing the controller does, and the flag clears as soon as the bus is seen idle-high again. When recovery is enabled, the controller first asks the switch to break the upstream connection. It then waits a settle delay and toggles the clock of each enabled channel, up to a bounded number of pulses. It stops early once the bus reads high and finishes with a stop condition. While it generates clocks and the stop condition, it inhibits the rise-time accelerators. The switch stays disconnected until software re-arms it: all channel enables go low, then at least one goes high again.

All time bases are counts of system-clock cycles. They come from a parameter that gives the clock rate in MHz, so a testbench can shrink the windows.

Top module: `stuck_bus_recovery`

## Requirements
- R1: The fault flag `fault_n` falls after `CLK_MHZ*STUCK_US` consecutive cycles in which the monitored bus is not high on both lines at once. Any single cycle with both lines high restarts that count.
- R2: The monitored bus is the AND over enabled channels only. A low on a channel whose `chan_en` bit is 0 never causes a fault, and with no channel enabled no fault can occur.
- R3: With `recover_en` low when the timeout expires, only `fault_n` is asserted. `disconnect`, `accel_inhibit` and both drive-low vectors stay 0, and `fault_n` returns high one cycle after the bus is sampled high on both lines.
- R4: With `recover_en` high, `disconnect` rises in the same cycle that `fault_n` falls.
- R5: After the disconnect, no clock is driven for `CLK_MHZ*SETTLE_US` cycles.
- R6: Recovery pulses hold SCL low for `HALF` cycles, then release it for `HALF` cycles, where `HALF = CLK_MHZ*1e6/(2*PULSE_HZ)`. At most `MAX_PULSES` pulses are sent, and only on channels whose `chan_en` bit is 1 (bit i of a drive vector belongs to channel i).
- R7: If both lines read high during a release phase, clocking ends at once, with no further pulse, and the stop condition starts on the next cycle.
- R8: The stop condition drives SDA and SCL low for `HALF` cycles, then SDA low with SCL released for `HALF` cycles, then releases SDA. If the bus was freed, `fault_n` returns high at that point while `disconnect` stays 1.
- R9: `accel_inhibit` is 1 during the pulse phases and the stop condition, and 0 during the settle delay and afterwards.
- R10: If the bus is still stuck after `MAX_PULSES` pulses, the stop condition is still issued, and `fault_n` stays low and `disconnect` stays high after it.
- R11: After a recovery, a cycle with `chan_en` all zero followed by any nonzero `chan_en` clears `disconnect`, releases `fault_n` and restarts monitoring.
- R12: After reset, `fault_n` is 1 and `disconnect`, `accel_inhibit` and both drive-low vectors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | NCH | Sampled SCL level of each downstream channel |
| sda_in | input | NCH | Sampled SDA level of each downstream channel |
| chan_en | input | NCH | Channel enable state of the switch |
| recover_en | input | 1 | Allows automatic disconnect and clocking |
| fault_n | output | 1 | Active-low stuck-bus flag |
| disconnect | output | 1 | Request to break the upstream connection |
| scl_drive_low | output | NCH | Open-drain SCL pull-down per channel |
| sda_drive_low | output | NCH | Open-drain SDA pull-down per channel |
| accel_inhibit | output | 1 | Disables the rise-time accelerators |

## Verification
The fault flag and the disconnect request change on the same clock edge, and a check made at only one of them could miss a one-cycle skew. The bench holds data low on an enabled channel from a known edge and samples both outputs a few cycles before and after the computed timeout boundary. A bound property adds that `disconnect` can never rise while `fault_n` is high. A second coincidence happens when the bus frees itself in the middle of a low phase. The release is then seen on the first cycle of the following high phase, and the bench confirms that the stop condition, not another pulse, follows, and that exactly three pulses were counted.

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
  parameter int NCH        = 2,
  parameter int CLK_MHZ    = 125,
  parameter int STUCK_US   = 45000,
  parameter int SETTLE_US  = 40,
  parameter int PULSE_HZ   = 5500,
  parameter int MAX_PULSES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] scl_in,
  input  logic [NCH-1:0] sda_in,
  input  logic [NCH-1:0] chan_en,
  input  logic           recover_en,
  output logic           fault_n,
  output logic           disconnect,
  output logic [NCH-1:0] scl_drive_low,
  output logic [NCH-1:0] sda_drive_low,
  output logic           accel_inhibit
);
  localparam int TOUT   = CLK_MHZ * STUCK_US;
  localparam int SETTLE = CLK_MHZ * SETTLE_US;
  localparam int HALF   = (CLK_MHZ * 1000000) / (2 * PULSE_HZ);
  localparam int MAXA   = (TOUT > SETTLE) ? TOUT : SETTLE;
  localparam int MAXC   = (MAXA > HALF) ? MAXA : HALF;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int PW     = $clog2(MAX_PULSES + 1);

  typedef enum logic [2:0] {
    S_MON, S_FLAG, S_SETTLE, S_CLO, S_CHI, S_STPA, S_STPB, S_HOLD
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic [PW-1:0] pulses;
  logic          freed;
  logic          off_seen;
  logic          bus_hi;
  logic          at_limit;

  assign bus_hi   = (&(scl_in | ~chan_en)) & (&(sda_in | ~chan_en));
  assign at_limit = (cnt == limit);

  always_comb begin
    case (st)
      S_MON:    limit = CW'(TOUT - 1);
      S_SETTLE: limit = CW'(SETTLE - 1);
      default:  limit = CW'(HALF - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_MON;
      cnt      <= '0;
      pulses   <= '0;
      freed    <= 1'b0;
      off_seen <= 1'b0;
    end else begin
      case (st)
        S_MON: begin
          if (bus_hi) cnt <= '0;
          else if (at_limit) begin
            cnt    <= '0;
            pulses <= '0;
            freed  <= 1'b0;
            st     <= recover_en ? S_SETTLE : S_FLAG;
          end else cnt <= cnt + 1'b1;
        end
        S_FLAG: begin
          if (bus_hi) begin
            cnt <= '0;
            st  <= S_MON;
          end
        end
        S_SETTLE: begin
          if (bus_hi) begin
            cnt   <= '0;
            freed <= 1'b1;
            st    <= S_STPA;
          end else if (at_limit) begin
            cnt <= '0;
            st  <= S_CLO;
          end else cnt <= cnt + 1'b1;
        end
        S_CLO: begin
          if (at_limit) begin
            cnt    <= '0;
            pulses <= pulses + 1'b1;
            st     <= S_CHI;
          end else cnt <= cnt + 1'b1;
        end
        S_CHI: begin
          if (bus_hi) begin
            cnt   <= '0;
            freed <= 1'b1;
            st    <= S_STPA;
          end else if (at_limit) begin
            cnt <= '0;
            st  <= (pulses == PW'(MAX_PULSES)) ? S_STPA : S_CLO;
          end else cnt <= cnt + 1'b1;
        end
        S_STPA: begin
          if (at_limit) begin
            cnt <= '0;
            st  <= S_STPB;
          end else cnt <= cnt + 1'b1;
        end
        S_STPB: begin
          if (at_limit) begin
            cnt      <= '0;
            off_seen <= 1'b0;
            st       <= S_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (chan_en == '0) off_seen <= 1'b1;
          else if (off_seen) begin
            off_seen <= 1'b0;
            cnt      <= '0;
            st       <= S_MON;
          end
        end
      endcase
    end
  end

  assign fault_n       = (st == S_MON) || (st == S_HOLD && freed);
  assign disconnect    = !(st inside {S_MON, S_FLAG});
  assign accel_inhibit = st inside {S_CLO, S_CHI, S_STPA, S_STPB};
  assign scl_drive_low = (st inside {S_CLO, S_STPA}) ? chan_en : '0;
  assign sda_drive_low = (st inside {S_STPA, S_STPB}) ? chan_en : '0;

endmodule

// File: rtl/stuck_bus_recovery_chk.sv
module stuck_bus_recovery_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic           recover_en,
  input logic           fault_n,
  input logic           disconnect,
  input logic [NCH-1:0] scl_drive_low,
  input logic [NCH-1:0] sda_drive_low,
  input logic           accel_inhibit
);
  assert_disc_with_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect) |-> !fault_n);

  assert_flag_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault_n) && !$past(recover_en)) |-> !disconnect);

  assert_idle_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en == '0 && fault_n) |=> fault_n);

  assert_settle_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect) |=> (scl_drive_low == '0));

  assert_pulse_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_drive_low != '0) || (sda_drive_low != '0)) |-> (accel_inhibit && disconnect));

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|sda_drive_low) |-> (scl_drive_low == '0));
endmodule

bind stuck_bus_recovery stuck_bus_recovery_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .recover_en(recover_en),
  .fault_n(fault_n), .disconnect(disconnect), .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low), .accel_inhibit(accel_inhibit)
);

// File: tb/stuck_bus_recovery_tb.sv
module stuck_bus_recovery_tb;
  localparam int NCH = 2;
  localparam int T   = 200;
  localparam int S   = 40;
  localparam int H   = 90;
  localparam int P0  = T - 1 + S;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] dev_scl = '1;
  logic [NCH-1:0] dev_sda = '1;
  logic [NCH-1:0] chan_en = '0;
  logic           recover_en = 1'b0;
  logic [NCH-1:0] scl_bus, sda_bus;
  logic           fault_n, disconnect, accel_inhibit;
  logic [NCH-1:0] scl_drive_low, sda_drive_low;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int seen_pulses = 0;
  logic prev_p = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    sig;
    int    exp;
    string tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_bus = dev_scl & ~scl_drive_low;
  assign sda_bus = dev_sda & ~sda_drive_low;

  stuck_bus_recovery #(
    .NCH(NCH), .CLK_MHZ(1), .STUCK_US(T), .SETTLE_US(S),
    .PULSE_HZ(5500), .MAX_PULSES(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .chan_en(chan_en), .recover_en(recover_en), .fault_n(fault_n),
    .disconnect(disconnect), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .accel_inhibit(accel_inhibit)
  );

  function automatic int get_sig(input int s);
    case (s)
      0: return int'(fault_n);
      1: return int'(disconnect);
      2: return int'(accel_inhibit);
      3: return int'(scl_drive_low);
      4: return int'(sda_drive_low);
      default: return seen_pulses;
    endcase
  endfunction

  task automatic expect_at(input int c, input int s, input int e, input string tag);
    item_t it;
    it.cyc = c; it.sig = s; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) tick();
  endtask

  task automatic rearm();
    int b;
    tick();
    chan_en = '0;
    repeat (3) tick();
    chan_en = 2'b01;
    b = cyc + 1;
    expect_at(b + 3, 1, 0, "R11");
    expect_at(b + 3, 0, 1, "R11");
    wait_to(b + 5);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if ((scl_drive_low[0] & ~sda_drive_low[0]) && !prev_p) seen_pulses++;
      prev_p = scl_drive_low[0] & ~sda_drive_low[0];
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.sig == 6) seen_pulses = 0;
        else begin
          n_tests++;
          if (it.cyc < cyc || get_sig(it.sig) != it.exp) begin
            n_fail++;
            $display("FAIL %s cyc %0d sig %0d: actual %0d expected %0d",
                     it.tag, it.cyc, it.sig, get_sig(it.sig), it.exp);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected finished");
      report();
      $finish;
    end
  end

  initial begin
    int b;
    repeat (4) tick();
    rst_n = 1'b1;
    b = cyc + 1;
    // R12 reset state
    expect_at(b + 1, 0, 1, "R12");
    expect_at(b + 1, 1, 0, "R12");
    expect_at(b + 1, 2, 0, "R12");
    expect_at(b + 1, 3, 0, "R12");
    expect_at(b + 1, 4, 0, "R12");
    wait_to(b + 3);

    // R2: disabled channel held low, then no channel enabled
    chan_en = 2'b01;
    dev_sda[1] = 1'b0;
    b = cyc + 1;
    expect_at(b + 2 * T, 0, 1, "R2");
    wait_to(b + 2 * T + 1);
    chan_en = 2'b00;
    dev_sda[0] = 1'b0;
    b = cyc + 1;
    expect_at(b + 2 * T, 0, 1, "R2");
    wait_to(b + 2 * T + 1);
    dev_sda[0] = 1'b1;
    chan_en = 2'b01;
    repeat (3) tick();

    // R1: one idle-high cycle restarts the window
    dev_sda[0] = 1'b0;
    b = cyc + 1;
    wait_to(b + T - 20);
    dev_sda[0] = 1'b1;
    tick();
    dev_sda[0] = 1'b0;
    b = cyc + 1;
    expect_at(b + T - 20, 0, 1, "R1");
    wait_to(b + T - 18);
    dev_sda[0] = 1'b1;
    repeat (3) tick();

    // full recovery on a bus that stays stuck
    recover_en = 1'b1;
    dev_sda[0] = 1'b0;
    b = cyc + 1;
    expect_at(b + T - 3, 0, 1, "R1");
    expect_at(b + T - 3, 1, 0, "R4");
    expect_at(b + T + 1, 0, 0, "R1");
    expect_at(b + T + 1, 1, 1, "R4");
    expect_at(b + T + 1, 3, 0, "R5");
    expect_at(b + T + 1, 2, 0, "R9");
    expect_at(b + T + 1, 6, 0, "mark");
    expect_at(b + P0 - 2, 3, 0, "R5");
    expect_at(b + P0 + 2, 3, 1, "R6");
    expect_at(b + P0 + 2, 2, 1, "R9");
    expect_at(b + P0 + H + 2, 3, 0, "R6");
    expect_at(b + P0 + 32 * H + 45, 3, 1, "R8");
    expect_at(b + P0 + 32 * H + 45, 4, 1, "R8");
    expect_at(b + P0 + 33 * H + 45, 3, 0, "R8");
    expect_at(b + P0 + 33 * H + 45, 4, 1, "R8");
    expect_at(b + P0 + 33 * H + 45, 2, 1, "R9");
    expect_at(b + P0 + 34 * H + 5, 5, 16, "R6");
    expect_at(b + P0 + 34 * H + 5, 4, 0, "R8");
    expect_at(b + P0 + 34 * H + 5, 0, 0, "R10");
    expect_at(b + P0 + 34 * H + 5, 1, 1, "R10");
    expect_at(b + P0 + 34 * H + 5, 2, 0, "R9");
    wait_to(b + P0 + 34 * H + 10);
    dev_sda[0] = 1'b1;
    b = cyc + 1;
    expect_at(b + 20, 1, 1, "R10");
    expect_at(b + 20, 0, 0, "R10");
    wait_to(b + 22);
    rearm();

    // early release during the third pulse
    dev_sda[0] = 1'b0;
    b = cyc + 1;
    expect_at(b + T + 1, 0, 0, "R1");
    expect_at(b + T + 1, 6, 0, "mark");
    expect_at(b + P0 + 5 * H + 20, 3, 1, "R7");
    expect_at(b + P0 + 5 * H + 20, 4, 1, "R7");
    expect_at(b + P0 + 7 * H + 10, 5, 3, "R7");
    expect_at(b + P0 + 7 * H + 10, 0, 1, "R8");
    expect_at(b + P0 + 7 * H + 10, 1, 1, "R8");
    expect_at(b + P0 + 7 * H + 10, 4, 0, "R8");
    wait_to(b + P0 + 4 * H + 45);
    dev_sda[0] = 1'b1;
    wait_to(b + P0 + 7 * H + 12);
    rearm();

    // R3: recovery disabled
    recover_en = 1'b0;
    dev_sda[0] = 1'b0;
    b = cyc + 1;
    expect_at(b + T + 5, 0, 0, "R3");
    expect_at(b + T + 5, 1, 0, "R3");
    expect_at(b + T + 50, 3, 0, "R3");
    expect_at(b + T + 50, 2, 0, "R3");
    expect_at(b + T + 50, 1, 0, "R3");
    wait_to(b + T + 60);
    dev_sda[0] = 1'b1;
    b = cyc + 1;
    expect_at(b + 2, 0, 1, "R3");
    wait_to(b + 4);

    while (q.size() > 0) tick();
    done = 1'b1;
    report();
    $finish;
  end
endmodule